// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block turns a master audio clock into the two timing signals a serial audio output needs: a bit clock, obtained by dividing the master clock by an integer ratio, and a frame (word-select) clock, obtained by counting a programmable number of bit periods. It also emits two single-cycle strobes in the master clock domain. One marks the last master cycle of each bit period. The other marks the last bit of each frame. A downstream serializer uses these strobes to shift data without sampling the generated clocks.

The configuration arrives on plain input fields. A build-time parameter selects how the divider field is read. In the log2 encoding, a 2-bit code gives ratio 2^code. In the minus-one encoding, a 6-bit value gives ratio value+1. Both generated clocks have independent polarity inversion.

All generation is gated by an enable. The configuration is captured only while the enable is low, and every rising enable restarts the bit and frame counters from zero.

Top module: `aud_bitframe_clkgen`

## Requirements
- R1: While the block is disabled, `bit_tick_o` and `frame_start_o` stay low. `bclk_o` equals the captured bit-clock inversion bit and `fclk_o` equals the captured frame-clock inversion bit.
- R2: With `ENC` = log2 encoding (0), the bit period in master cycles is R = 2^`cfg_div_log2`, which gives 1, 2, 4 or 8.
- R3: With `ENC` = minus-one encoding (1), the bit period is R = `cfg_div_m1` + 1, covering 1 to 64.
- R4: Within each bit period, the uninverted bit clock is high during master cycles 0 to floor(R/2)-1 and low for the rest. For R = 1 it alternates every master cycle, starting high.
- R5: `bit_tick_o` is high exactly on the last master cycle of each bit period, which for R = 1 is every cycle.
- R6: A frame lasts `cfg_frame_m1` + 1 bit periods. `frame_start_o` is high exactly on the bit tick that ends the last bit of a frame, so the next master cycle opens a new frame.
- R7: The uninverted frame clock is low for the first floor((`cfg_frame_m1`+1)/2) bits of a frame and high for the remaining bits. It changes only in the master cycle right after a bit tick.
- R8: `cfg_inv_bclk` inverts `bclk_o` and `cfg_inv_fclk` inverts `fclk_o`, and neither changes the strobes.
- R9: The divider, frame and inversion fields are captured only while `cfg_en` is low. Changes made while the block runs have no effect on any output.
- R10: The first master cycle after `cfg_en` is sampled high is cycle 0 of bit 0 of frame 0.
- R11: The divider field that the selected encoding does not use has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Divider enable; low stops and clears generation and opens configuration capture |
| cfg_div_log2 | input | LOG_W | Log2 of the bit-clock ratio (log2 encoding) |
| cfg_div_m1 | input | DIV_W | Bit-clock ratio minus one (minus-one encoding) |
| cfg_frame_m1 | input | FRM_W | Bit periods per frame minus one (63 nominal) |
| cfg_inv_bclk | input | 1 | Invert the bit clock output |
| cfg_inv_fclk | input | 1 | Invert the frame clock output |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| bit_tick_o | output | 1 | Strobe on the last master cycle of each bit period |
| frame_start_o | output | 1 | Strobe on the bit tick that closes a frame |

## Verification
A wrong bit counter or a mis-decoded ratio shows at the ports within one bit period: a strobe arrives early or late, or the high phase of `bclk_o` has the wrong length. A wrong frame counter shows within one frame, as a misplaced `frame_start_o` or as an `fclk_o` edge that does not follow a bit tick. If the counters are not cleared on re-enable, the first cycles after enable already differ from the bit-0, frame-0 pattern. The bench compares every output on every master cycle against an arithmetic model, for every ratio of both encodings, so any of these faults is reported at the first cycle it appears.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
  typedef enum logic {
    DIV_ENC_LOG2   = 1'b0,
    DIV_ENC_MINUS1 = 1'b1
  } div_enc_e;
endpackage

// File: rtl/aud_clkgen_cfg_hold.sv
module aud_clkgen_cfg_hold
  import aud_clkgen_pkg::*;
#(
  parameter div_enc_e ENC   = DIV_ENC_LOG2,
  parameter int       LOG_W = 2,
  parameter int       DIV_W = 6,
  parameter int       FRM_W = 12,
  localparam int      RAT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LOG_W-1:0] div_log2,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [FRM_W-1:0] frame_m1,
  input  logic             inv_b,
  input  logic             inv_f,
  output logic [RAT_W-1:0] ratio_q,
  output logic [FRM_W-1:0] frm_q,
  output logic             inv_b_q,
  output logic             inv_f_q
);
  // Master cycles per bit period, per the selected field encoding.
  function automatic logic [RAT_W-1:0] decode_ratio(input logic [LOG_W-1:0] lg,
                                                    input logic [DIV_W-1:0] m1);
    if (ENC == DIV_ENC_LOG2) return RAT_W'(1) << lg;
    else                     return {1'b0, m1} + RAT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RAT_W'(1);
      frm_q   <= '0;
      inv_b_q <= 1'b0;
      inv_f_q <= 1'b0;
    end else if (load) begin
      ratio_q <= decode_ratio(div_log2, div_m1);
      frm_q   <= frame_m1;
      inv_b_q <= inv_b;
      inv_f_q <= inv_f;
    end
  end
endmodule

// File: rtl/aud_clkgen_bit_div.sv
module aud_clkgen_bit_div #(
  parameter int  DIV_W = 6,
  localparam int RAT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [RAT_W-1:0] ratio,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             bclk_raw_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tog_q;
  logic             last;
  logic [RAT_W-1:0] half;

  assign last   = ({1'b0, cnt_q} == (ratio - RAT_W'(1)));
  assign half   = ratio >> 1;
  assign tick_o = run & last;
  assign cnt_o  = cnt_q;

  // Ratio one: alternate every master cycle, first cycle high.
  assign bclk_raw_o = run & ((ratio == RAT_W'(1)) ? ~tog_q : ({1'b0, cnt_q} < half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (run) begin
      cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
      tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/aud_clkgen_frame_ctr.sv
module aud_clkgen_frame_ctr #(
  parameter int FRM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             bit_tick,
  input  logic [FRM_W-1:0] frm_m1,
  output logic [FRM_W-1:0] fcnt_o,
  output logic             frame_o,
  output logic             fclk_raw_o
);
  logic [FRM_W-1:0] fcnt_q;
  logic             flast;
  logic [FRM_W:0]   half;

  assign flast      = (fcnt_q == frm_m1);
  assign half       = ({1'b0, frm_m1} + (FRM_W + 1)'(1)) >> 1;
  assign frame_o    = bit_tick & flast;
  assign fclk_raw_o = run & ({1'b0, fcnt_q} >= half);
  assign fcnt_o     = fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fcnt_q <= '0;
    else if (clr)       fcnt_q <= '0;
    else if (bit_tick)  fcnt_q <= flast ? '0 : fcnt_q + FRM_W'(1);
  end
endmodule

// File: rtl/aud_bitframe_clkgen.sv
module aud_bitframe_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter div_enc_e ENC   = DIV_ENC_LOG2,
  parameter int       LOG_W = 2,
  parameter int       DIV_W = 6,
  parameter int       FRM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [LOG_W-1:0] cfg_div_log2,
  input  logic [DIV_W-1:0] cfg_div_m1,
  input  logic [FRM_W-1:0] cfg_frame_m1,
  input  logic             cfg_inv_bclk,
  input  logic             cfg_inv_fclk,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             bit_tick_o,
  output logic             frame_start_o
);
  localparam int RAT_W = DIV_W + 1;

  logic             run_q;
  logic             stop;
  logic [RAT_W-1:0] ratio_q;
  logic [FRM_W-1:0] frm_q;
  logic             inv_b_q, inv_f_q;
  logic [DIV_W-1:0] bit_cnt;
  logic [FRM_W-1:0] frm_cnt;
  logic             bit_tick, frame_tick, bclk_raw, fclk_raw;

  assign stop = ~cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= cfg_en;
  end

  aud_clkgen_cfg_hold #(.ENC(ENC), .LOG_W(LOG_W), .DIV_W(DIV_W), .FRM_W(FRM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(stop),
    .div_log2(cfg_div_log2), .div_m1(cfg_div_m1), .frame_m1(cfg_frame_m1),
    .inv_b(cfg_inv_bclk), .inv_f(cfg_inv_fclk),
    .ratio_q(ratio_q), .frm_q(frm_q), .inv_b_q(inv_b_q), .inv_f_q(inv_f_q)
  );

  aud_clkgen_bit_div #(.DIV_W(DIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .clr(stop), .run(run_q), .ratio(ratio_q),
    .cnt_o(bit_cnt), .tick_o(bit_tick), .bclk_raw_o(bclk_raw)
  );

  aud_clkgen_frame_ctr #(.FRM_W(FRM_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .clr(stop), .run(run_q), .bit_tick(bit_tick),
    .frm_m1(frm_q), .fcnt_o(frm_cnt), .frame_o(frame_tick), .fclk_raw_o(fclk_raw)
  );

  assign bclk_o        = bclk_raw ^ inv_b_q;
  assign fclk_o        = fclk_raw ^ inv_f_q;
  assign bit_tick_o    = bit_tick;
  assign frame_start_o = frame_tick;
endmodule

// File: rtl/aud_bitframe_clkgen_chk.sv
module aud_bitframe_clkgen_chk #(
  parameter int  DIV_W = 6,
  parameter int  FRM_W = 12,
  localparam int RAT_W = DIV_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             bclk_o,
  input logic             fclk_o,
  input logic             bit_tick_o,
  input logic             frame_start_o,
  input logic             inv_b_q,
  input logic             inv_f_q,
  input logic [RAT_W-1:0] ratio_q,
  input logic [FRM_W-1:0] frm_q,
  input logic [DIV_W-1:0] bit_cnt,
  input logic [FRM_W-1:0] frm_cnt
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!bit_tick_o && !frame_start_o));

  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (bclk_o == inv_b_q && fclk_o == inv_f_q));

  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, bit_cnt} < ratio_q);

  a_r6_frame_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> bit_tick_o);

  a_r7_fclk_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$stable(fclk_o)) |-> $past(bit_tick_o));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(ratio_q) && $stable(frm_q) &&
                                 $stable(inv_b_q) && $stable(inv_f_q)));

  a_r10_clean_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (bit_cnt == '0 && frm_cnt == '0));
endmodule

bind aud_bitframe_clkgen aud_bitframe_clkgen_chk #(.DIV_W(DIV_W), .FRM_W(FRM_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .bclk_o(bclk_o), .fclk_o(fclk_o),
  .bit_tick_o(bit_tick_o), .frame_start_o(frame_start_o), .inv_b_q(inv_b_q),
  .inv_f_q(inv_f_q), .ratio_q(ratio_q), .frm_q(frm_q), .bit_cnt(bit_cnt),
  .frm_cnt(frm_cnt)
);

// File: tb/test_aud_bitframe_clkgen.sv
module test_aud_bitframe_clkgen;
  import aud_clkgen_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // log2-encoded instance
  logic       l_en = 1'b0, l_ib = 1'b0, l_if = 1'b0;
  logic [1:0] l_lg = '0;
  logic [5:0] l_m1 = '0;
  logic [11:0] l_fr = '0;
  logic       l_bclk, l_fclk, l_tick, l_frm;
  // minus-one-encoded instance
  logic       e_en = 1'b0, e_ib = 1'b0, e_if = 1'b0;
  logic [1:0] e_lg = '0;
  logic [5:0] e_m1 = '0;
  logic [11:0] e_fr = '0;
  logic       e_bclk, e_fclk, e_tick, e_frm;

  aud_bitframe_clkgen #(.ENC(DIV_ENC_LOG2)) i_aud_bitframe_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_en(l_en), .cfg_div_log2(l_lg), .cfg_div_m1(l_m1),
    .cfg_frame_m1(l_fr), .cfg_inv_bclk(l_ib), .cfg_inv_fclk(l_if),
    .bclk_o(l_bclk), .fclk_o(l_fclk), .bit_tick_o(l_tick), .frame_start_o(l_frm)
  );

  aud_bitframe_clkgen #(.ENC(DIV_ENC_MINUS1)) i_aud_bitframe_clkgen_ext (
    .clk(clk), .rst_n(rst_n), .cfg_en(e_en), .cfg_div_log2(e_lg), .cfg_div_m1(e_m1),
    .cfg_frame_m1(e_fr), .cfg_inv_bclk(e_ib), .cfg_inv_fclk(e_if),
    .bclk_o(e_bclk), .fclk_o(e_fclk), .bit_tick_o(e_tick), .frame_start_o(e_frm)
  );

  bit wd_expired = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_expired = 1'b1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample(input bit ext, output logic b, output logic f,
                        output logic t, output logic s);
    b = ext ? e_bclk : l_bclk;
    f = ext ? e_fclk : l_fclk;
    t = ext ? e_tick : l_tick;
    s = ext ? e_frm  : l_frm;
  endtask

  // One configuration: program while disabled, run, compare every cycle, disable.
  task automatic run_case(input bit ext, input int sel, input int fm1,
                          input bit ib, input bit ifl, input bit poke_mid,
                          input int junk);
    int r, ncyc, pos, bitn, fpos;
    logic b, f, t, s, eb, ef, et, es;
    r = ext ? sel + 1 : (1 << sel);
    ncyc = 2 * (fm1 + 1) * r + 3;
    @(negedge clk);
    if (ext) begin
      e_en = 0; e_m1 = 6'(sel); e_lg = 2'(junk); e_fr = 12'(fm1); e_ib = ib; e_if = ifl;
    end else begin
      l_en = 0; l_lg = 2'(sel); l_m1 = 6'(junk); l_fr = 12'(fm1); l_ib = ib; l_if = ifl;
    end
    repeat (2) @(negedge clk);
    sample(ext, b, f, t, s);
    chk("R1 idle bclk", b, ib);
    chk("R1 idle fclk", f, ifl);
    chk("R1 idle tick", t, 1'b0);
    chk("R1 idle frame", s, 1'b0);
    if (ext) e_en = 1; else l_en = 1;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      pos  = n % r;
      bitn = n / r;
      fpos = bitn % (fm1 + 1);
      eb = ((r == 1) ? (n % 2 == 0) : (pos < r / 2)) ^ ib;
      et = (pos == r - 1);
      es = et && (fpos == fm1);
      ef = (fpos >= (fm1 + 1) / 2) ^ ifl;
      sample(ext, b, f, t, s);
      // R2/R3 ratio, R4 waveform, R8 polarity, R10 restart, R11 unused field
      chk(ext ? "R3 R4 R8 R10 R11 bclk" : "R2 R4 R8 R10 R11 bclk", b, eb);
      chk("R5 bit tick", t, et);
      chk("R6 frame strobe", s, es);
      chk("R7 R8 fclk", f, ef);
      if (poke_mid && n == ncyc / 2) begin
        // R9: changes while enabled must not affect outputs
        if (ext) begin
          e_m1 = ~e_m1; e_fr = e_fr + 12'd3; e_ib = ~e_ib; e_if = ~e_if;
        end else begin
          l_lg = ~l_lg; l_fr = l_fr + 12'd3; l_ib = ~l_ib; l_if = ~l_if;
        end
      end
    end
    if (ext) e_en = 0; else l_en = 0;
    @(negedge clk);
    sample(ext, b, f, t, s);
    chk("R1 stop tick", t, 1'b0);
    chk("R1 stop frame", s, 1'b0);
  endtask

  initial begin
    logic b, f, t, s;
    repeat (3) @(negedge clk);
    sample(1'b0, b, f, t, s);
    chk("R1 reset bclk", b, 1'b0);
    chk("R1 reset fclk", f, 1'b0);
    chk("R1 reset tick", t, 1'b0);
    chk("R1 reset frame", s, 1'b0);
    rst_n = 1'b1;

    // Log2 encoding: all codes against small, odd and nominal frame lengths
    for (int code = 0; code < 4; code++) begin
      run_case(1'b0, code, 1,  code[0], code[1], 1'b0, 5 + code);
      run_case(1'b0, code, 4,  ~code[0], code[1], 1'b1, 63 - code);
      run_case(1'b0, code, 63, code[1], ~code[0], 1'b0, code * 7);
      run_case(1'b0, code, 0,  1'b0, 1'b1, 1'b0, 1);
    end
    // Minus-one encoding: every ratio 1..64
    for (int m = 0; m < 64; m++) begin
      run_case(1'b1, m, (m % 2 == 0) ? 2 : 5, m[0], m[1], (m % 5 == 0), m + 1);
    end
    run_case(1'b1, 0, 63, 1'b1, 1'b0, 1'b1, 3);
    run_case(1'b1, 63, 1, 1'b0, 1'b1, 1'b1, 2);

    if (wd_expired) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (wd_expired);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule